// File: doc/BRIEF.md
# Zero-After-Ones Serial Detector

This block watches a serial bit stream, one bit per clock, and flags the first zero that follows one or more ones. It has two state bits. The state walks through a fixed Gray-style sequence while ones keep arriving. It holds in a saturating "many ones" state until a zero arrives. On that zero it returns to idle.

The flag is a Mealy output. It is combinational in the present state and the present input bit. It is therefore valid in the same cycle that the zero is presented, before the clock edge that clears the state. The two state bits are brought out for observation.

The state register resets asynchronously on an active-low reset. The flag is held low while reset is asserted. The input bit must be stable around the rising clock edge.

Top module: `zero_after_ones_det`

## Requirements
- R1: While rst_ni is low, state_o is 2'b00 and y_o is 0, regardless of x_i and without waiting for a clock edge.
- R2: In state 2'b00, x_i=0 keeps state 2'b00 with y_o=0, and x_i=1 moves to 2'b01 with y_o=0.
- R3: In state 2'b01, x_i=0 gives y_o=1 and a return to 2'b00, and x_i=1 gives y_o=0 and a move to 2'b11.
- R4: In state 2'b11, x_i=0 gives y_o=1 and a return to 2'b00, and x_i=1 gives y_o=0 and a move to 2'b10.
- R5: In state 2'b10, x_i=1 holds state 2'b10 with y_o=0, and x_i=0 gives y_o=1 and a return to 2'b00.
- R6: y_o follows a change of x_i within a cycle, with no clock edge in between.
- R7: y_o is 1 exactly in a cycle where x_i=0 and at least one 1 has arrived since the last reset or the last cycle with y_o=1. The state is 2'b00 after every such cycle. state_o[1] is the bit A and state_o[0] is the bit B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| x_i | input | 1 | Serial input bit |
| y_o | output | 1 | Mealy detect flag |
| state_o | output | 2 | Present state {A,B} |

## Verification
The saturating state 2'b10 is reached only after three consecutive ones, and the fifth-one case checks that it really holds. The stimulus therefore includes directed runs of one, two, three and five ones, each closed by a zero, followed by a long random stream checked against a behavioural model. Reset is applied in the middle of a cycle while the flag is high in state 2'b10. This shows that reset clears both the state and the flag at once. A separate test toggles x_i twice inside one cycle in state 2'b01 to show the output reacting with no clock edge.

// File: rtl/zdet_pkg.sv
package zdet_pkg;
  localparam int unsigned ST_W = 2;
  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b11,
    ST_MANY = 2'b10
  } zdet_st_e;
endpackage

// File: rtl/zdet_next.sv
module zdet_next
  import zdet_pkg::*;
(
  input  zdet_st_e cur_i,
  input  logic     x_i,
  output zdet_st_e nxt_o
);
  logic a, b, a_n, b_n;
  assign a   = cur_i[1];
  assign b   = cur_i[0];
  assign a_n = (a & x_i) | (b & x_i);
  assign b_n = ~a & x_i;
  assign nxt_o = zdet_st_e'({a_n, b_n});
endmodule

// File: rtl/zdet_out.sv
module zdet_out
  import zdet_pkg::*;
(
  input  logic     en_i,
  input  zdet_st_e cur_i,
  input  logic     x_i,
  output logic     y_o
);
  assign y_o = en_i & (cur_i[1] | cur_i[0]) & ~x_i;

  // R1
  always_comb begin
    if (!en_i) begin
      rst_flag_low_chk: assert (y_o == 1'b0);
    end
  end
endmodule

// File: rtl/zero_after_ones_det.sv
module zero_after_ones_det
  import zdet_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       x_i,
  output logic       y_o,
  output logic [1:0] state_o
);
  zdet_st_e state_q, state_d;

  zdet_next u_next (.cur_i(state_q), .x_i(x_i), .nxt_o(state_d));
  zdet_out  u_out  (.en_i(rst_ni), .cur_i(state_q), .x_i(x_i), .y_o(y_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  idle_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00 && !x_i) |=> state_o == 2'b00);
  // R2
  idle_to_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00 && x_i) |=> state_o == 2'b01);
  // R3
  one_to_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01 && x_i) |=> state_o == 2'b11);
  // R4
  two_to_many_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b11 && x_i) |=> state_o == 2'b10);
  // R5
  many_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && x_i) |=> state_o == 2'b10);
  // R7
  detect_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_o |=> state_o == 2'b00);
  // R7
  flag_needs_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_o |-> (!x_i && state_o != 2'b00));
endmodule

// File: tb/sim_zero_after_ones_det.sv
`timescale 1ns/1ps
module sim_zero_after_ones_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x = 1'b0;
  logic y;
  logic [1:0] st;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  zero_after_ones_det u0 (.clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_o(y), .state_o(st));

  // entry: {x, expected y, expected next state}; starts in 2'b00
  localparam int N = 18;
  localparam logic [3:0] TBL [N] = '{
    4'b0_0_00, 4'b1_0_01, 4'b0_1_00,
    4'b1_0_01, 4'b1_0_11, 4'b0_1_00,
    4'b1_0_01, 4'b1_0_11, 4'b1_0_10, 4'b0_1_00,
    4'b1_0_01, 4'b1_0_11, 4'b1_0_10, 4'b1_0_10, 4'b1_0_10, 4'b0_1_00,
    4'b0_0_00, 4'b0_0_00
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [1:0] s);
    case (s)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b11: return "R4";
      default: return "R5";
    endcase
  endfunction

  // behavioural model from the transition description
  function automatic logic [2:0] model(input logic [1:0] s, input logic xb);
    if (!xb) return {(s != 2'b00), 2'b00};
    case (s)
      2'b00: return 3'b0_01;
      2'b01: return 3'b0_11;
      default: return 3'b0_10;
    endcase
  endfunction

  task automatic step(input logic xb, input logic ey, input logic [1:0] ens, input string req);
    @(negedge clk);
    x = xb;
    #2;
    chk({req, " y"}, {1'b0, y}, {1'b0, ey});
    @(posedge clk);
    #2;
    chk({req, " state"}, st, ens);
  endtask

  initial begin
    logic [1:0] ms;
    logic [2:0] r;
    #5;
    chk("R1 reset state", st, 2'b00);
    x = 1'b1;
    #1;
    chk("R1 reset flag", {1'b0, y}, 2'b00);
    x = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    ms = 2'b00;
    for (int i = 0; i < N; i++) begin
      step(TBL[i][3], TBL[i][2], TBL[i][1:0], tag_of(ms));
      ms = TBL[i][1:0];
    end

    // R7 random stream against model
    for (int i = 0; i < 400; i++) begin
      logic xb;
      xb = ($urandom_range(0, 99) < 65);
      r = model(ms, xb);
      step(xb, r[2], r[1:0], "R7");
      ms = r[1:0];
    end

    // R6 flag follows x inside one cycle in state 2'b01
    step(1'b0, ms != 2'b00, 2'b00, "R7");
    step(1'b1, 1'b0, 2'b01, "R2");
    @(negedge clk);
    x = 1'b1;
    #2;
    chk("R6 x=1", {1'b0, y}, 2'b00);
    x = 1'b0;
    #2;
    chk("R6 x=0", {1'b0, y}, 2'b01);
    x = 1'b1;
    #2;
    chk("R6 x=1 again", {1'b0, y}, 2'b00);
    @(posedge clk);
    #2;
    chk("R3 state", st, 2'b11);
    step(1'b1, 1'b0, 2'b10, "R4");

    // R1 asynchronous reset mid-cycle while flag high in 2'b10
    @(negedge clk);
    x = 1'b0;
    #2;
    chk("R5 flag before reset", {1'b0, y}, 2'b01);
    rst_n = 1'b0;
    #1;
    chk("R1 async state", st, 2'b00);
    chk("R1 async flag", {1'b0, y}, 2'b00);
    @(negedge clk);
    x = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 held in reset", st, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    x = 1'b0;
    #2;
    chk("R7 no ones since reset", {1'b0, y}, 2'b00);
    step(1'b1, 1'b0, 2'b01, "R2");
    step(1'b0, 1'b1, 2'b00, "R3");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule